// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block takes interrupt requests from a set of sources and decides whether the core is interrupted and at which of two vector addresses it starts. Each source brings a request flag, an enable and a priority select. Source 0 is fixed: it counts as high priority whatever its priority select says. A mode input chooses between single-level operation, where every interrupt goes to one vector, and two-level operation, where each priority group has its own global enable and its own vector.

The two global enables are registers inside the block. Software loads them through a write strobe. The controller clears one of them when the core takes an interrupt, and sets it again when a return strobe arrives. The controller records which handler levels are active. A low-priority handler can therefore be preempted by a high-priority request, but a high-priority handler cannot be interrupted at all. The request and the vector are registered outputs. The core acknowledges a request with a one-cycle strobe.

Top module: `prio_irq_ctrl`

## Requirements
- R1: During reset and after it, `irq_req` is 0 and `irq_vec` is 0x000008. Both global enables reset to 0, so flagged and enabled sources raise no request until software sets an enable.
- R2: A source is counted only when both its `src_flag` bit and its `src_en` bit are 1. Clearing one source's enable blocks that source and no other.
- R3: In two-level mode (`two_level`=1), a source whose priority select is 1 ("high") needs the high global enable. It raises `irq_req` with `irq_vec` = 0x000008.
- R4: In two-level mode, a source whose priority select is 0 ("low") needs both the low and the high global enable. It raises `irq_req` with `irq_vec` = 0x000018.
- R5: Source 0 (bit 0) is always high priority. Its `src_prio` bit has no effect.
- R6: In single-level mode (`two_level`=0), every request uses vector 0x000008. Source 0 needs only the high global enable. All other sources need both global enables, with the low enable acting as the enable for the peripheral group.
- R7: When high and low requests are both qualified, the high vector 0x000008 is presented.
- R8: An `irq_ack` while `irq_req`=1 takes the interrupt. Taking a high interrupt (or any interrupt in single-level mode) clears the high global enable. Taking a low interrupt clears only the low global enable, so a high request can still preempt.
- R9: An `irq_reti` pulse sets again the global enable that was cleared for the innermost active handler: the high level first if it is active, otherwise the low level.
- R10: `irq_req` and `irq_vec` follow the inputs and the enables one clock later. In the cycle after an acknowledge, `irq_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| two_level | input | 1 | 1 = two-level priority mode, 0 = single-level mode |
| ge_wr | input | 1 | Write strobe for both global enables |
| ge_hi_d | input | 1 | Value written to the high global enable |
| ge_lo_d | input | 1 | Value written to the low global enable |
| src_flag | input | NUM_SRC | Per-source request flags |
| src_en | input | NUM_SRC | Per-source enables |
| src_prio | input | NUM_SRC | Per-source priority select, 1 = high (bit 0 ignored) |
| irq_ack | input | 1 | Core takes the presented interrupt |
| irq_reti | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | ADDR_W | Vector address for the request |

## Verification
The main function is tested with a single high source, a single low source, and source 0 with its priority select forced low. Together these separate the group gating from the source 0 override. Pairs of sources where only one has both its flag and its enable set show that qualification and masking apply per source. The same low source, run once in single-level mode and once in two-level mode, shows the mode switch: the vector changes and the meaning of the low enable changes. A nested run (low taken, high preempts, two returns) checks that the enables are cleared and restored in the right order. It also checks that a pending low request stays blocked until its own level is restored.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    CLS_LO = 1'b0,
    CLS_HI = 1'b1
  } irq_cls_t;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_SRC = 18
) (
  input  logic [NUM_SRC-1:0] flag,
  input  logic [NUM_SRC-1:0] en,
  input  logic [NUM_SRC-1:0] prio,
  input  logic               two_level,
  input  logic               ge_hi,
  input  logic               ge_lo,
  output logic               hi_pend,
  output logic               lo_pend
);
  localparam logic [NUM_SRC-1:0] FIXED_MASK = NUM_SRC'(1);

  logic [NUM_SRC-1:0] live;
  logic [NUM_SRC-1:0] eff_prio;
  logic [NUM_SRC-1:0] hi_live;
  logic [NUM_SRC-1:0] lo_live;

  // Source 0 is forced into the high group.
  assign eff_prio = prio | FIXED_MASK;
  assign live     = flag & en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_split
    assign hi_live[i] = live[i] & eff_prio[i];
    assign lo_live[i] = live[i] & ~eff_prio[i];
  end

  always_comb begin
    if (two_level) begin
      hi_pend = ge_hi & (|hi_live);
      lo_pend = ge_hi & ge_lo & (|lo_live);
    end else begin
      // Single level: fixed source needs only the high enable,
      // the rest also need the peripheral (low) enable.
      hi_pend = ge_hi & ((|(live & FIXED_MASK)) | (ge_lo & (|(live & ~FIXED_MASK))));
      lo_pend = 1'b0;
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ge_wr,
  input  logic     ge_hi_d,
  input  logic     ge_lo_d,
  input  logic     enter,
  input  irq_cls_t enter_cls,
  input  logic     reti,
  output logic     ge_hi,
  output logic     ge_lo,
  output logic     in_hi
);
  logic in_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      ge_hi <= 1'b0;
      ge_lo <= 1'b0;
      in_hi <= 1'b0;
      in_lo <= 1'b0;
    end else begin
      if (ge_wr) begin
        ge_hi <= ge_hi_d;
        ge_lo <= ge_lo_d;
      end
      if (enter) begin
        if (enter_cls == CLS_HI) begin
          in_hi <= 1'b1;
          ge_hi <= 1'b0;
        end else begin
          in_lo <= 1'b1;
          ge_lo <= 1'b0;
        end
      end else if (reti) begin
        if (in_hi) begin
          in_hi <= 1'b0;
          ge_hi <= 1'b1;
        end else if (in_lo) begin
          in_lo <= 1'b0;
          ge_lo <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                NUM_SRC = 18,
  parameter int                ADDR_W  = 21,
  parameter logic [ADDR_W-1:0] HI_VEC  = ADDR_W'(8),
  parameter logic [ADDR_W-1:0] LO_VEC  = ADDR_W'(24)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               two_level,
  input  logic               ge_wr,
  input  logic               ge_hi_d,
  input  logic               ge_lo_d,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] src_prio,
  input  logic               irq_ack,
  input  logic               irq_reti,
  output logic               irq_req,
  output logic [ADDR_W-1:0]  irq_vec
);
  logic     hi_pend, lo_pend;
  logic     ge_hi, ge_lo, in_hi;
  logic     enter;
  irq_cls_t cls_q;

  irq_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .flag      (src_flag),
    .en        (src_en),
    .prio      (src_prio),
    .two_level (two_level),
    .ge_hi     (ge_hi),
    .ge_lo     (ge_lo),
    .hi_pend   (hi_pend),
    .lo_pend   (lo_pend)
  );

  assign enter = irq_ack & irq_req;

  irq_nest u_nest (
    .clk       (clk),
    .rst       (rst),
    .ge_wr     (ge_wr),
    .ge_hi_d   (ge_hi_d),
    .ge_lo_d   (ge_lo_d),
    .enter     (enter),
    .enter_cls (cls_q),
    .reti      (irq_reti),
    .ge_hi     (ge_hi),
    .ge_lo     (ge_lo),
    .in_hi     (in_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= HI_VEC;
      cls_q   <= CLS_HI;
    end else begin
      irq_req <= (hi_pend | lo_pend) & ~enter;
      if (!hi_pend && lo_pend) begin
        irq_vec <= LO_VEC;
        cls_q   <= CLS_LO;
      end else begin
        irq_vec <= HI_VEC;
        cls_q   <= CLS_HI;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int                ADDR_W = 21,
  parameter logic [ADDR_W-1:0] HI_VEC = ADDR_W'(8),
  parameter logic [ADDR_W-1:0] LO_VEC = ADDR_W'(24)
) (
  input logic              clk,
  input logic              rst,
  input logic              two_level,
  input logic              irq_ack,
  input logic              irq_reti,
  input logic              irq_req,
  input logic [ADDR_W-1:0] irq_vec,
  input logic              hi_pend,
  input logic              ge_hi,
  input logic              in_hi
);
  a_r3_vec_legal: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec == HI_VEC || irq_vec == LO_VEC));

  a_r10_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req);

  a_r7_high_wins: assert property (@(posedge clk) disable iff (rst)
    (hi_pend && !(irq_ack && irq_req)) |=> (irq_req && irq_vec == HI_VEC));

  a_r6_single_vec: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(two_level)) |-> (irq_vec == HI_VEC));

  a_r8_hi_entry_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && irq_vec == HI_VEC) |=> !ge_hi);

  a_r9_reti_restores_hi: assert property (@(posedge clk) disable iff (rst)
    (irq_reti && !(irq_ack && irq_req) && in_hi) |=> ge_hi);
endmodule

bind prio_irq_ctrl irq_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .HI_VEC (HI_VEC),
  .LO_VEC (LO_VEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .two_level (two_level),
  .irq_ack   (irq_ack),
  .irq_reti  (irq_reti),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec),
  .hi_pend   (hi_pend),
  .ge_hi     (ge_hi),
  .in_hi     (in_hi)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N = 18;
  localparam int AW = 21;
  localparam logic [AW-1:0] VH = AW'(8);
  localparam logic [AW-1:0] VL = AW'(24);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic two_level = 1'b0;
  logic ge_wr = 1'b0, ge_hi_d = 1'b0, ge_lo_d = 1'b0;
  logic [N-1:0] src_flag = '0, src_en = '0, src_prio = '0;
  logic irq_ack = 1'b0, irq_reti = 1'b0;
  logic irq_req;
  logic [AW-1:0] irq_vec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .two_level(two_level),
    .ge_wr(ge_wr), .ge_hi_d(ge_hi_d), .ge_lo_d(ge_lo_d),
    .src_flag(src_flag), .src_en(src_en), .src_prio(src_prio),
    .irq_ack(irq_ack), .irq_reti(irq_reti),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_req(input logic r, input string tag);
    chk(irq_req === r, tag, 32'(irq_req), 32'(r));
  endtask

  task automatic expect_irq(input logic [AW-1:0] v, input string tag);
    chk(irq_req === 1'b1, tag, 32'(irq_req), 32'd1);
    chk(irq_vec === v, tag, 32'(irq_vec), 32'(v));
  endtask

  task automatic clean_reset();
    rst = 1'b1; two_level = 1'b0; ge_wr = 1'b0; irq_ack = 1'b0; irq_reti = 1'b0;
    src_flag = '0; src_en = '0; src_prio = '0;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic set_ge(input logic h, input logic l);
    ge_hi_d = h; ge_lo_d = l; ge_wr = 1'b1;
    tick(1);
    ge_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; src_flag = '1; src_en = '1; src_prio = '1; two_level = 1'b1;
    tick(2);
    expect_req(1'b0, "R1 req in reset");
    chk(irq_vec === VH, "R1 vec in reset", 32'(irq_vec), 32'(VH));
    rst = 1'b0;
    tick(3);
    expect_req(1'b0, "R1 enables cleared after reset");
  endtask

  task automatic t_high();
    clean_reset();
    two_level = 1'b1;
    set_ge(1'b1, 1'b0);
    src_prio[5] = 1'b1; src_en[5] = 1'b1; src_flag[5] = 1'b1;
    tick(1);
    expect_irq(VH, "R3/R10 high source one cycle later");
    set_ge(1'b0, 1'b1);
    tick(1);
    expect_req(1'b0, "R3 high gated by high enable");
  endtask

  task automatic t_low();
    clean_reset();
    two_level = 1'b1;
    src_en[7] = 1'b1; src_flag[7] = 1'b1;
    set_ge(1'b1, 1'b1);
    tick(1);
    expect_irq(VL, "R4 low vector");
    set_ge(1'b0, 1'b1);
    tick(1);
    expect_req(1'b0, "R4 low needs high enable too");
    set_ge(1'b1, 1'b0);
    tick(1);
    expect_req(1'b0, "R4 low gated by low enable");
  endtask

  task automatic t_src0();
    clean_reset();
    two_level = 1'b1;
    src_prio[0] = 1'b0; src_en[0] = 1'b1; src_flag[0] = 1'b1;
    set_ge(1'b1, 1'b0);
    tick(1);
    expect_irq(VH, "R5 source 0 always high");
  endtask

  task automatic t_enable();
    clean_reset();
    two_level = 1'b1;
    src_prio[4:3] = 2'b11;
    set_ge(1'b1, 1'b0);
    src_en[3] = 1'b1;
    tick(2);
    expect_req(1'b0, "R2 enable without flag");
    src_flag[4] = 1'b1;
    tick(2);
    expect_req(1'b0, "R2 flag without enable");
    src_en[4] = 1'b1; src_en[3] = 1'b0;
    tick(2);
    expect_irq(VH, "R2 other source unaffected by mask");
  endtask

  task automatic t_single();
    clean_reset();
    two_level = 1'b0;
    src_en[9] = 1'b1; src_flag[9] = 1'b1;
    set_ge(1'b1, 1'b1);
    tick(1);
    expect_irq(VH, "R6 single mode uses high vector");
    set_ge(1'b1, 1'b0);
    tick(1);
    expect_req(1'b0, "R6 peripheral enable gates source 9");
    src_en[0] = 1'b1; src_flag[0] = 1'b1;
    tick(2);
    expect_irq(VH, "R6 source 0 needs only high enable");
  endtask

  task automatic t_both();
    clean_reset();
    two_level = 1'b1;
    src_prio[2] = 1'b1;
    src_en[3:2] = 2'b11; src_flag[3:2] = 2'b11;
    set_ge(1'b1, 1'b1);
    tick(1);
    expect_irq(VH, "R7 high wins over low");
  endtask

  task automatic t_nest();
    clean_reset();
    two_level = 1'b1;
    src_prio[2] = 1'b1;
    src_en[3:2] = 2'b11; src_flag[3] = 1'b1;
    set_ge(1'b1, 1'b1);
    tick(1);
    expect_irq(VL, "R8 low presented");
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    expect_req(1'b0, "R10 req drops after ack");
    tick(1);
    expect_req(1'b0, "R8 low enable cleared on low entry");
    src_flag[2] = 1'b1;
    tick(1);
    expect_irq(VH, "R8 high preempts low handler");
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    tick(1);
    expect_req(1'b0, "R8 high enable cleared on high entry");
    irq_reti = 1'b1;
    tick(1);
    irq_reti = 1'b0;
    tick(1);
    expect_irq(VH, "R9 reti restores high enable first");
    src_flag[2] = 1'b0;
    tick(2);
    expect_req(1'b0, "R9 low still blocked before second reti");
    irq_reti = 1'b1;
    tick(1);
    irq_reti = 1'b0;
    tick(1);
    expect_irq(VL, "R9 second reti restores low enable");
  endtask

  initial begin
    tick(1);
    t_reset();
    t_high();
    t_low();
    t_src0();
    t_enable();
    t_single();
    t_both();
    t_nest();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule